// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from 8-bit segments. A rising clock edge loads it in parallel, or steps it up or down by one, or leaves it as it is. A raw asynchronous clear empties it at any moment. The counter compares its own value with the end of the range for the selected direction. From that it drives a terminal-count flag and an enable-out signal, so a further counter can be chained behind it without a ripple through the carry.

Inside, `SEGS` segments of `SEG_W` bits are chained. Each segment's enable-out feeds the count enable of the segment above it. Clock, direction, load and clear go to every segment in parallel. Together the segments behave as one counter of `SEG_W*SEGS` bits that wraps modulo 2^(SEG_W*SEGS). The clear is used as a raw asynchronous reset and is active high. It is not synchronised, so a caller that needs a clean release must time the falling edge of `clear` against the clock.

Top module: `updown_chain`

## Requirements
- R1: While `clear` is high, `count` is all zeros and `tc` and `ceo` are low, whatever the clock and the other inputs do. This holds from the moment `clear` rises, without waiting for a clock edge.
- R2: When `load` is high at a rising edge, `count` takes the value of `din`, whether `ce` is high or low.
- R3: When `load` and `ce` are both high at the same edge, the load wins and no step is taken.
- R4: With `load` low, `ce` high and `up` = 1, `count` goes up by one at each edge. All ones wraps to all zeros.
- R5: With `load` low, `ce` high and `up` = 0, `count` goes down by one at each edge. All zeros wraps to all ones.
- R6: With `load` and `ce` both low, a clock edge leaves `count` unchanged.
- R7: `tc` is 1 when `up` = 1 and every bit of `count` is 1. It is also 1 when `up` = 0 and every bit of `count` is 0. Otherwise it is 0. It follows `count` and `up` without a clock delay.
- R8: `ceo` equals `tc` AND `ce`, with no clock delay.
- R9: A segment steps only when every segment below it is at its terminal value for the current direction. The whole value therefore carries and borrows across segment boundaries, for example 0x00FF up to 0x0100 and 0x0100 down to 0x00FF.
- R10: If `clear` is pulsed and released between two clock edges, the next edge acts on the cleared value as a normal edge would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Parallel load enable |
| din | input | SEG_W*SEGS | Parallel load value |
| ce | input | 1 | Count enable |
| up | input | 1 | Direction: 1 = count up, 0 = count down |
| count | output | SEG_W*SEGS | Current counter value |
| tc | output | 1 | Terminal count for the current direction |
| ceo | output | 1 | Enable-out for a following counter |

## Verification
Two situations are hard to reach from the ports. One is a carry or borrow across a segment boundary, which needs the low segment to sit at its terminal value at exactly the edge when counting is enabled. The other is a clear that both rises and falls inside one clock period. The stimulus covers the first case by loading values just below and just above each boundary, such as 0x00FF, 0x0100, 0xFFFF and 0x0000, before counting. The random phase draws most of its load values from those same edges. For the second case the bench raises and drops `clear` between two edges, checks the cleared outputs while `clear` is still high, and then checks the first normal step after the release.

// File: rtl/updown_pkg.sv
`timescale 1ns/1ps
// updown_pkg: shared constants and types for the cascadable counter.
// Assumes: all segments share one width given by SEG_W_DEF.
package updown_pkg;
    localparam int unsigned SEG_W_DEF = 8;
    localparam int unsigned SEGS_DEF  = 2;

    // Direction encoding used by the up input
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/updown_term.sv
`timescale 1ns/1ps
// updown_term: terminal-value detector for one segment.
// Reports 1 when the value is all ones while counting up, or all zeros
// while counting down. A high clear forces it to 0.
// Assumes: purely combinational; the caller supplies the registered value.
module updown_term #(
    parameter int unsigned W = updown_pkg::SEG_W_DEF
) (
    input  logic [W-1:0] value,
    input  logic         up,
    input  logic         clear,
    output logic         at_end
);
    import updown_pkg::*;

    logic all_ones;
    logic all_zeros;

    // Detect both range ends and select one by direction
    always_comb begin
        all_ones  = &value;
        all_zeros = ~|value;
        if (clear)
            at_end = 1'b0;
        else if (dir_e'(up) == DIR_UP)
            at_end = all_ones;
        else
            at_end = all_zeros;
    end
endmodule

// File: rtl/updown_seg.sv
`timescale 1ns/1ps
// updown_seg: one counter segment with parallel load, up/down step,
// asynchronous clear, terminal flag and enable-out.
// Priority: clear, then load, then count enable.
// Assumes: clear is a raw asynchronous reset, active high.
module updown_seg #(
    parameter int unsigned W = updown_pkg::SEG_W_DEF
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ce,
    input  logic         up,
    output logic [W-1:0] value,
    output logic         at_end,
    output logic         en_out
);
    import updown_pkg::*;

    logic [W-1:0] value_nx;

    // Choose the next value: load, step or hold
    always_comb begin
        if (load)
            value_nx = din;
        else if (ce && dir_e'(up) == DIR_UP)
            value_nx = value + 1'b1;
        else if (ce)
            value_nx = value - 1'b1;
        else
            value_nx = value;
    end

    // Segment register with asynchronous clear
    always_ff @(posedge clk or posedge clear) begin
        if (clear)
            value <= '0;
        else
            value <= value_nx;
    end

    updown_term #(.W(W)) u_term (
        .value  (value),
        .up     (up),
        .clear  (clear),
        .at_end (at_end)
    );

    // Pass the enable on only at the terminal value
    always_comb en_out = at_end & ce;
endmodule

// File: rtl/updown_chain.sv
`timescale 1ns/1ps
// updown_chain: SEGS counter segments chained into one wide counter.
// Each segment's enable-out feeds the count enable of the segment above.
// Clock, clear, load and direction go to every segment in parallel.
// Assumes: a single clock period covers the enable path through all segments.
module updown_chain #(
    parameter int unsigned SEG_W = updown_pkg::SEG_W_DEF,
    parameter int unsigned SEGS  = updown_pkg::SEGS_DEF
) (
    input  logic                  clk,
    input  logic                  clear,
    input  logic                  load,
    input  logic [SEG_W*SEGS-1:0] din,
    input  logic                  ce,
    input  logic                  up,
    output logic [SEG_W*SEGS-1:0] count,
    output logic                  tc,
    output logic                  ceo
);
    localparam int unsigned TOT_W = SEG_W * SEGS;

    logic [SEGS:0]   en_link;
    logic [SEGS-1:0] seg_end;

    // Feed the external enable into the lowest segment
    always_comb en_link[0] = ce;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        updown_seg #(.W(SEG_W)) u_seg (
            .clk    (clk),
            .clear  (clear),
            .load   (load),
            .din    (din[s*SEG_W +: SEG_W]),
            .ce     (en_link[s]),
            .up     (up),
            .value  (count[s*SEG_W +: SEG_W]),
            .at_end (seg_end[s]),
            .en_out (en_link[s+1])
        );
    end

    // The whole counter is at its end only when every segment is
    always_comb tc = &seg_end;

    // The top segment's enable-out already includes ce and all lower ends
    always_comb ceo = en_link[SEGS];

    logic [TOT_W-1:0] unused_w;
    always_comb unused_w = '0;
endmodule

// File: rtl/updown_chain_chk.sv
`timescale 1ns/1ps
// updown_chain_chk: property checker bound to updown_chain.
// Assumes: inputs change away from the rising clock edge.
module updown_chain_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         clear,
    input logic         load,
    input logic [W-1:0] din,
    input logic         ce,
    input logic         up,
    input logic [W-1:0] count,
    input logic         tc,
    input logic         ceo
);
    // Marks the first edge after any clear pulse, so steps across it are skipped
    logic clr_gap;
    always_ff @(posedge clk or posedge clear) begin
        if (clear)
            clr_gap <= 1'b1;
        else
            clr_gap <= 1'b0;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        clear |-> (count == '0 && !tc && !ceo)); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clear)
        load |=> (clr_gap || count == $past(din))); // R2

    AST_LOAD_OVER_COUNT: assert property (@(posedge clk) disable iff (clear)
        (load && ce) |=> (clr_gap || count == $past(din))); // R3

    AST_STEP_UP: assert property (@(posedge clk) disable iff (clear)
        (!load && ce && up) |=> (clr_gap || count == $past(count) + 1'b1)); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clear)
        (!load && ce && !up) |=> (clr_gap || count == $past(count) - 1'b1)); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (clear)
        (!load && !ce) |=> (clr_gap || $stable(count))); // R6

    AST_TC_SOUND: assert property (@(posedge clk) disable iff (clear)
        tc |-> (up ? (&count) : (~|count))); // R7

    AST_TC_COMPLETE: assert property (@(posedge clk) disable iff (clear)
        (up ? (&count) : (~|count)) |-> tc); // R7

    AST_CEO_GATE: assert property (@(posedge clk) disable iff (clear)
        ceo == (tc && ce)); // R8
endmodule

bind updown_chain updown_chain_chk #(.W(SEG_W*SEGS)) u_chk (
    .clk   (clk),
    .clear (clear),
    .load  (load),
    .din   (din),
    .ce    (ce),
    .up    (up),
    .count (count),
    .tc    (tc),
    .ceo   (ceo)
);

// File: tb/updown_chain_test.sv
`timescale 1ns/1ps
module updown_chain_test;
    localparam int SEG_W = 8;
    localparam int SEGS  = 2;
    localparam int W     = SEG_W * SEGS;

    logic         clk = 1'b0;
    logic         clear = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] din = '0;
    logic         ce = 1'b0;
    logic         up = 1'b0;
    logic [W-1:0] count;
    logic         tc;
    logic         ceo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model = '0;

    always #2.5 clk = ~clk;

    updown_chain #(.SEG_W(SEG_W), .SEGS(SEGS)) uut (
        .clk(clk), .clear(clear), .load(load), .din(din),
        .ce(ce), .up(up), .count(count), .tc(tc), .ceo(ceo)
    );

    function automatic logic [W-1:0] f_next(input logic [W-1:0] cur, input logic ld,
                                             input logic [W-1:0] d, input logic en,
                                             input logic dir);
        if (ld) return d;
        if (en) return dir ? cur + 1'b1 : cur - 1'b1;
        return cur;
    endfunction

    function automatic logic f_tc(input logic [W-1:0] cur, input logic dir, input logic clr);
        if (clr) return 1'b0;
        return dir ? (&cur) : (~|cur);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " count"}, count, model);
        check({req, " tc R7"}, W'(tc), W'(f_tc(model, up, clear)));
        check({req, " ceo R8"}, W'(ceo), W'(f_tc(model, up, clear) & ce));
    endtask

    // Drive inputs just after a falling edge, clock once, check at the next falling edge
    task automatic cycle(input logic ld, input logic [W-1:0] d, input logic en,
                         input logic dir, input string req);
        load = ld; din = d; ce = en; up = dir;
        @(posedge clk);
        model = f_next(model, ld, d, en, dir);
        @(negedge clk);
        check_outs(req);
    endtask

    // Clear raised and dropped between two edges, then one enabled up step
    task automatic mid_clear();
        load = 1'b0; ce = 1'b1; up = 1'b1;
        #1 clear = 1'b1;
        #0.5;
        model = '0;
        check_outs("R1 mid-cycle clear");
        #0.5 clear = 1'b0;
        @(posedge clk);
        model = f_next(model, 1'b0, '0, 1'b1, 1'b1);
        @(negedge clk);
        check_outs("R10 step after release");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd4242);
        // R1: clear held across clock edges
        repeat (3) @(negedge clk);
        load = 1'b1; din = 16'hABCD; ce = 1'b1; up = 1'b0;
        @(negedge clk);
        model = '0;
        check_outs("R1 clear held");
        load = 1'b0; ce = 1'b0;
        clear = 1'b0;
        #0.5;
        check_outs("R7 down at zero");
        @(negedge clk);

        cycle(1'b1, 16'hFFFF, 1'b0, 1'b1, "R2 load with ce low");
        ce = 1'b1; #0.5;
        check_outs("R8 ceo at all ones");
        @(negedge clk);
        cycle(1'b0, '0, 1'b1, 1'b1, "R4 wrap up");
        cycle(1'b0, '0, 1'b1, 1'b0, "R5 wrap down");
        cycle(1'b1, 16'h00FF, 1'b0, 1'b1, "R2 load");
        cycle(1'b0, '0, 1'b1, 1'b1, "R9 carry across segments");
        cycle(1'b0, '0, 1'b1, 1'b0, "R9 borrow across segments");
        cycle(1'b1, 16'h1234, 1'b1, 1'b1, "R3 load beats count");
        cycle(1'b0, '0, 1'b0, 1'b1, "R6 hold up");
        cycle(1'b0, '0, 1'b0, 1'b0, "R6 hold down");
        cycle(1'b1, 16'h5555, 1'b0, 1'b1, "R2 load");
        mid_clear();

        for (int i = 0; i < 500; i++) begin
            logic ld;
            logic en;
            logic dir;
            logic [W-1:0] d;
            int sel;
            if ($urandom_range(0, 31) == 0) begin
                mid_clear();
            end else begin
                ld  = ($urandom_range(0, 7) == 0);
                en  = ($urandom_range(0, 3) != 0);
                dir = 1'($urandom_range(0, 1));
                sel = $urandom_range(0, 5);
                case (sel)
                    0: d = 16'h0000;
                    1: d = 16'hFFFF;
                    2: d = 16'h00FF;
                    3: d = 16'h0100;
                    4: d = 16'hFFFE;
                    default: d = W'($urandom);
                endcase
                cycle(ld, d, en, dir, "R4 R5 R9 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule